// File: doc/BRIEF.md
# DRAM Clock Frequency Change Sequencer

This block steps a DRAM subsystem through a safe change of its memory clock. After a request is accepted it holds off all bus masters, lets in-flight traffic drain, suspends ZQ calibration and auto-refresh, and rescales the refresh interval to suit the new clock band. It then parks the memory in self-refresh, asks the clock unit for the new frequency, and reinitialises the PHY. Once the PHY is ready it leaves self-refresh and retrains the DQS gate. It then applies the type-dependent termination and gate-extend settings, restores refresh and ZQ calibration, and lets the masters back in.

The block does not touch the controller's registers itself. It issues one-cycle register write events (a target selector plus a 32-bit word) and drives level request lines toward the controller, the clock unit and the PHY. Register contents that are only partly modified (ZQ control, refresh timing, gate configuration) are taken from inputs and captured when the request is accepted. Every status poll has a programmable timeout, and an expired timeout parks the sequencer in an error state.

Top module: `dfs_freq_seq`

## Requirements
- R1: A request while idle or in error is accepted; `busy_o` and `master_block_o` are high in the cycle after. Requests during a sequence are ignored, and the sequence uses the target, type and register values captured at acceptance.
- R2: The first write (selector 0, ZQ control) comes exactly PRE_US×CLK_MHZ cycles after `master_block_o` rises. Its data is the captured ZQ word with bits [13:11] cleared.
- R3: The refresh-timing write (selector 1) follows one cycle after the ZQ write, and `refresh_off_o` rises with it. Bits [27:16] carry the nominal interval shifted right by 2 below 300 MHz, shifted right by 1 from 300 to 671 MHz, and unshifted at 672 MHz and above; all other bits keep the captured value. `refresh_off_o` stays high until the final ZQ restore write.
- R4: `sr_req_o` rises one cycle after the refresh-timing write. `clk_req_o` is raised only after `opmode_i` reads 3 and is held until `clk_ack_i`.
- R5: On clock acknowledge, a PHY command write (selector 2) is issued: 0x40020061 for targets at or below 800 MHz, 0x40000071 above. The sequencer then waits for `phy_done_i`.
- R6: When the PHY reports done, `sr_req_o` falls. The next step waits EXIT_US×CLK_MHZ cycles and then for `opmode_i` to read 1, so the gate write comes EXIT_US×CLK_MHZ+1 cycles after the fall when the status is already 1.
- R7: A gate-configuration write (selector 3) with bits [7:6] cleared precedes gate training. Training is a PHY command write in the next cycle: 0x40020C01/0x40000C01 for type code 3, and 0x40020401/0x40000401 for other types, split at 800 MHz as in R5.
- R8: After training completes, type code 3 gets an ODT-map write (selector 4) of 0 below 400 MHz and 0x00002211 otherwise; other types get no ODT write.
- R9: Type codes 6 and 7 get a second gate-configuration write with bits [7:6] = 01 after training; other types get none.
- R10: The sequence ends with a ZQ write of the original captured word, with `refresh_off_o` falling in the same cycle. In the next cycle `master_block_o` and `busy_o` fall and `done_o` pulses for one cycle.
- R11: If a polled condition stays false, `err_o` rises tmo_limit_i+1 cycles after the poll state is entered and `busy_o` falls; the other request levels hold. A new request restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Frequency change request |
| target_mhz_i | input | FREQ_W | Target memory clock in MHz |
| dram_type_i | input | 3 | Memory type code (3 DDR3, 6 LPDDR2, 7 LPDDR3) |
| trefi_nom_i | input | 12 | Nominal refresh interval at full rate |
| zq_cur_i | input | 32 | Current ZQ control register |
| rfsh_cur_i | input | 32 | Current refresh timing register |
| gate_cur_i | input | 32 | Current gate configuration register |
| tmo_limit_i | input | TMO_W | Poll timeout limit in cycles |
| opmode_i | input | 3 | Controller operating mode status |
| clk_ack_i | input | 1 | Clock unit switch acknowledge |
| phy_done_i | input | 1 | PHY general status done bit |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Poll timeout error |
| master_block_o | output | 1 | Master access blocked |
| refresh_off_o | output | 1 | Auto-refresh disabled |
| sr_req_o | output | 1 | Self-refresh request |
| clk_req_o | output | 1 | Clock switch request |
| clk_tgt_o | output | FREQ_W | Frequency presented to the clock unit |
| wr_valid_o | output | 1 | Register write event |
| wr_sel_o | output | 3 | Write target: 0 ZQ, 1 refresh timing, 2 PHY command, 3 gate config, 4 ODT map |
| wr_data_o | output | 32 | Write data |

## Verification
Every output is registered, so each result appears a fixed number of cycles after the state that produces it. The ZQ write lands exactly PRE_US×CLK_MHZ cycles after the block rises. The refresh-timing write and `refresh_off_o` rise one cycle later, and `sr_req_o` one cycle after that. The gate-clear write lands EXIT_US×CLK_MHZ+1 cycles after `sr_req_o` falls, and `done_o` comes one cycle after the ZQ restore. A timeout error lands tmo_limit_i+1 cycles after the poll begins. The bench stamps every output event with a cycle number sampled on the falling edge and compares the differences between stamps to these offsets, so response latencies of the external models do not enter the checks.

// File: rtl/dfs_seq_pkg.sv
package dfs_seq_pkg;

    localparam int REG_W     = 32;
    localparam int TREFI_W   = 12;
    localparam int TREFI_LSB = 16;

    localparam logic [REG_W-1:0] ZQ_EN_MASK    = 32'h0000_3800;
    localparam logic [REG_W-1:0] TREFI_MASK    = 32'h0FFF_0000;
    localparam logic [REG_W-1:0] GATE_EXT_MASK = 32'h0000_00C0;
    localparam logic [REG_W-1:0] GATE_EXT_ONE  = 32'h0000_0040;

    localparam logic [REG_W-1:0] PHY_INIT_BYP = 32'h4002_0061;
    localparam logic [REG_W-1:0] PHY_INIT_PLL = 32'h4000_0071;
    localparam logic [REG_W-1:0] TRN_D3_BYP   = 32'h4002_0C01;
    localparam logic [REG_W-1:0] TRN_D3_PLL   = 32'h4000_0C01;
    localparam logic [REG_W-1:0] TRN_GEN_BYP  = 32'h4002_0401;
    localparam logic [REG_W-1:0] TRN_GEN_PLL  = 32'h4000_0401;
    localparam logic [REG_W-1:0] ODT_MAP_LOW  = 32'h0000_0000;
    localparam logic [REG_W-1:0] ODT_MAP_HIGH = 32'h0000_2211;

    localparam int MHZ_BAND_LO  = 300;
    localparam int MHZ_BAND_HI  = 672;
    localparam int MHZ_PHY_PLL  = 800;
    localparam int MHZ_ODT_ON   = 400;

    localparam logic [2:0] TYPE_DDR3 = 3'd3;
    localparam logic [2:0] TYPE_LP2  = 3'd6;
    localparam logic [2:0] TYPE_LP3  = 3'd7;

    localparam logic [2:0] OPM_NORMAL = 3'd1;
    localparam logic [2:0] OPM_SELFRF = 3'd3;

    typedef enum logic [2:0] {
        SEL_ZQ   = 3'd0,
        SEL_RFSH = 3'd1,
        SEL_PHY  = 3'd2,
        SEL_GATE = 3'd3,
        SEL_ODT  = 3'd4
    } wr_sel_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BLK_WAIT,
        ST_RF_OFF,
        ST_SR_ON,
        ST_SR_POLL,
        ST_CLK_POLL,
        ST_PHY_POLL,
        ST_EXIT_WAIT,
        ST_NORM_POLL,
        ST_TRAIN,
        ST_TRAIN_POLL,
        ST_GX_SET,
        ST_RF_ON,
        ST_FINISH,
        ST_ERR
    } seq_state_e;

endpackage

// File: rtl/dfs_word_calc.sv
module dfs_word_calc
    import dfs_seq_pkg::*;
#(
    parameter int FREQ_W = 12
) (
    input  logic [FREQ_W-1:0]  tgt_i,
    input  logic [2:0]         type_i,
    input  logic [TREFI_W-1:0] nom_i,
    input  logic [REG_W-1:0]   rf_base_i,
    input  logic [REG_W-1:0]   gate_base_i,
    input  logic [REG_W-1:0]   zq_base_i,
    output logic [REG_W-1:0]   zq_off_word_o,
    output logic [REG_W-1:0]   rf_word_o,
    output logic [REG_W-1:0]   init_word_o,
    output logic [REG_W-1:0]   train_word_o,
    output logic               odt_en_o,
    output logic [REG_W-1:0]   odt_word_o,
    output logic               gx_en_o,
    output logic [REG_W-1:0]   gate_clr_word_o,
    output logic [REG_W-1:0]   gate_ext_word_o
);

    localparam logic [FREQ_W-1:0] F_LO  = FREQ_W'(MHZ_BAND_LO);
    localparam logic [FREQ_W-1:0] F_HI  = FREQ_W'(MHZ_BAND_HI);
    localparam logic [FREQ_W-1:0] F_PLL = FREQ_W'(MHZ_PHY_PLL);
    localparam logic [FREQ_W-1:0] F_ODT = FREQ_W'(MHZ_ODT_ON);

    logic [TREFI_W-1:0] trefi_scaled;
    logic               phy_bypass;
    logic               is_ddr3;

    always_comb begin
        if (tgt_i < F_LO) begin
            trefi_scaled = nom_i >> 2;
        end else if (tgt_i < F_HI) begin
            trefi_scaled = nom_i >> 1;
        end else begin
            trefi_scaled = nom_i;
        end
    end

    assign phy_bypass = (tgt_i <= F_PLL);
    assign is_ddr3    = (type_i == TYPE_DDR3);

    assign zq_off_word_o   = zq_base_i & ~ZQ_EN_MASK;
    assign rf_word_o       = (rf_base_i & ~TREFI_MASK)
                           | ({{(REG_W-TREFI_W){1'b0}}, trefi_scaled} << TREFI_LSB);
    assign init_word_o     = phy_bypass ? PHY_INIT_BYP : PHY_INIT_PLL;
    assign train_word_o    = is_ddr3 ? (phy_bypass ? TRN_D3_BYP  : TRN_D3_PLL)
                                     : (phy_bypass ? TRN_GEN_BYP : TRN_GEN_PLL);
    assign odt_en_o        = is_ddr3;
    assign odt_word_o      = (tgt_i < F_ODT) ? ODT_MAP_LOW : ODT_MAP_HIGH;
    assign gx_en_o         = (type_i == TYPE_LP2) || (type_i == TYPE_LP3);
    assign gate_clr_word_o = gate_base_i & ~GATE_EXT_MASK;
    assign gate_ext_word_o = (gate_base_i & ~GATE_EXT_MASK) | GATE_EXT_ONE;

endmodule

// File: rtl/dfs_poll_timer.sv
module dfs_poll_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expired_o
);

    localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (run_i && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = run_i && (cnt_q == limit_i);

    // R11: the wait counter saturates and never wraps back to zero by itself
    a_r11_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clear_i) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/dfs_freq_seq.sv
module dfs_freq_seq
    import dfs_seq_pkg::*;
#(
    parameter int FREQ_W  = 12,
    parameter int TMO_W   = 16,
    parameter int CLK_MHZ = 100,
    parameter int PRE_US  = 20,
    parameter int EXIT_US = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [FREQ_W-1:0] target_mhz_i,
    input  logic [2:0]        dram_type_i,
    input  logic [11:0]       trefi_nom_i,
    input  logic [31:0]       zq_cur_i,
    input  logic [31:0]       rfsh_cur_i,
    input  logic [31:0]       gate_cur_i,
    input  logic [TMO_W-1:0]  tmo_limit_i,
    input  logic [2:0]        opmode_i,
    input  logic              clk_ack_i,
    input  logic              phy_done_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              master_block_o,
    output logic              refresh_off_o,
    output logic              sr_req_o,
    output logic              clk_req_o,
    output logic [FREQ_W-1:0] clk_tgt_o,
    output logic              wr_valid_o,
    output logic [2:0]        wr_sel_o,
    output logic [31:0]       wr_data_o
);

    localparam int PRE_CYC  = PRE_US * CLK_MHZ;
    localparam int EXIT_CYC = EXIT_US * CLK_MHZ;
    localparam int MAX_CYC  = (PRE_CYC > EXIT_CYC) ? PRE_CYC : EXIT_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_state_e          state;
        logic [CNT_W-1:0]    cnt;
        logic [FREQ_W-1:0]   tgt;
        logic [2:0]          typ;
        logic [TREFI_W-1:0]  nom;
        logic [REG_W-1:0]    zq;
        logic [REG_W-1:0]    rf;
        logic [REG_W-1:0]    gate;
        logic                busy;
        logic                done;
        logic                err;
        logic                mblk;
        logic                rfoff;
        logic                sr;
        logic                clkr;
        logic                wv;
        wr_sel_e             wsel;
        logic [REG_W-1:0]    wdata;
    } seq_t;

    seq_t s_d, s_q;

    logic [REG_W-1:0] zq_off_word, rf_word, init_word, train_word;
    logic [REG_W-1:0] odt_word, gate_clr_word, gate_ext_word;
    logic             odt_en, gx_en;
    logic             poll_run, poll_clear, poll_expired;

    dfs_word_calc #(
        .FREQ_W (FREQ_W)
    ) u_word_calc (
        .tgt_i           (s_q.tgt),
        .type_i          (s_q.typ),
        .nom_i           (s_q.nom),
        .rf_base_i       (s_q.rf),
        .gate_base_i     (s_q.gate),
        .zq_base_i       (s_q.zq),
        .zq_off_word_o   (zq_off_word),
        .rf_word_o       (rf_word),
        .init_word_o     (init_word),
        .train_word_o    (train_word),
        .odt_en_o        (odt_en),
        .odt_word_o      (odt_word),
        .gx_en_o         (gx_en),
        .gate_clr_word_o (gate_clr_word),
        .gate_ext_word_o (gate_ext_word)
    );

    assign poll_run = (s_q.state == ST_SR_POLL)   || (s_q.state == ST_CLK_POLL)  ||
                      (s_q.state == ST_PHY_POLL)  || (s_q.state == ST_NORM_POLL) ||
                      (s_q.state == ST_TRAIN_POLL);
    assign poll_clear = (s_d.state != s_q.state);

    dfs_poll_timer #(
        .TMO_W (TMO_W)
    ) u_poll_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (poll_clear),
        .run_i     (poll_run),
        .limit_i   (tmo_limit_i),
        .expired_o (poll_expired)
    );

    always_comb begin
        s_d      = s_q;
        s_d.wv   = 1'b0;
        s_d.done = 1'b0;
        unique case (s_q.state)
            ST_IDLE, ST_ERR: begin
                if (req_i) begin
                    s_d.state = ST_BLK_WAIT;
                    s_d.cnt   = CNT_W'(PRE_CYC - 1);
                    s_d.tgt   = target_mhz_i;
                    s_d.typ   = dram_type_i;
                    s_d.nom   = trefi_nom_i;
                    s_d.zq    = zq_cur_i;
                    s_d.rf    = rfsh_cur_i;
                    s_d.gate  = gate_cur_i;
                    s_d.busy  = 1'b1;
                    s_d.err   = 1'b0;
                    s_d.mblk  = 1'b1;
                end
            end
            ST_BLK_WAIT: begin
                if (s_q.cnt == '0) begin
                    s_d.state = ST_RF_OFF;
                    s_d.wv    = 1'b1;
                    s_d.wsel  = SEL_ZQ;
                    s_d.wdata = zq_off_word;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_RF_OFF: begin
                s_d.state = ST_SR_ON;
                s_d.rfoff = 1'b1;
                s_d.wv    = 1'b1;
                s_d.wsel  = SEL_RFSH;
                s_d.wdata = rf_word;
            end
            ST_SR_ON: begin
                s_d.state = ST_SR_POLL;
                s_d.sr    = 1'b1;
            end
            ST_SR_POLL: begin
                if (opmode_i == OPM_SELFRF) begin
                    s_d.state = ST_CLK_POLL;
                    s_d.clkr  = 1'b1;
                end else if (poll_expired) begin
                    s_d.state = ST_ERR;
                end
            end
            ST_CLK_POLL: begin
                if (clk_ack_i) begin
                    s_d.state = ST_PHY_POLL;
                    s_d.clkr  = 1'b0;
                    s_d.wv    = 1'b1;
                    s_d.wsel  = SEL_PHY;
                    s_d.wdata = init_word;
                end else if (poll_expired) begin
                    s_d.state = ST_ERR;
                end
            end
            ST_PHY_POLL: begin
                if (phy_done_i) begin
                    s_d.state = ST_EXIT_WAIT;
                    s_d.sr    = 1'b0;
                    s_d.cnt   = CNT_W'(EXIT_CYC - 1);
                end else if (poll_expired) begin
                    s_d.state = ST_ERR;
                end
            end
            ST_EXIT_WAIT: begin
                if (s_q.cnt == '0) begin
                    s_d.state = ST_NORM_POLL;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_NORM_POLL: begin
                if (opmode_i == OPM_NORMAL) begin
                    s_d.state = ST_TRAIN;
                    s_d.wv    = 1'b1;
                    s_d.wsel  = SEL_GATE;
                    s_d.wdata = gate_clr_word;
                end else if (poll_expired) begin
                    s_d.state = ST_ERR;
                end
            end
            ST_TRAIN: begin
                s_d.state = ST_TRAIN_POLL;
                s_d.wv    = 1'b1;
                s_d.wsel  = SEL_PHY;
                s_d.wdata = train_word;
            end
            ST_TRAIN_POLL: begin
                if (phy_done_i) begin
                    s_d.state = ST_GX_SET;
                    if (odt_en) begin
                        s_d.wv    = 1'b1;
                        s_d.wsel  = SEL_ODT;
                        s_d.wdata = odt_word;
                    end
                end else if (poll_expired) begin
                    s_d.state = ST_ERR;
                end
            end
            ST_GX_SET: begin
                s_d.state = ST_RF_ON;
                if (gx_en) begin
                    s_d.wv    = 1'b1;
                    s_d.wsel  = SEL_GATE;
                    s_d.wdata = gate_ext_word;
                end
            end
            ST_RF_ON: begin
                s_d.state = ST_FINISH;
                s_d.rfoff = 1'b0;
                s_d.wv    = 1'b1;
                s_d.wsel  = SEL_ZQ;
                s_d.wdata = s_q.zq;
            end
            ST_FINISH: begin
                s_d.state = ST_IDLE;
                s_d.mblk  = 1'b0;
                s_d.busy  = 1'b0;
                s_d.done  = 1'b1;
            end
            default: begin
                s_d.state = ST_IDLE;
            end
        endcase
        if (s_d.state == ST_ERR && s_q.state != ST_ERR) begin
            s_d.err  = 1'b1;
            s_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
            s_q.wsel  <= SEL_ZQ;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o         = s_q.busy;
    assign done_o         = s_q.done;
    assign err_o          = s_q.err;
    assign master_block_o = s_q.mblk;
    assign refresh_off_o  = s_q.rfoff;
    assign sr_req_o       = s_q.sr;
    assign clk_req_o      = s_q.clkr;
    assign clk_tgt_o      = s_q.tgt;
    assign wr_valid_o     = s_q.wv;
    assign wr_sel_o       = s_q.wsel;
    assign wr_data_o      = s_q.wdata;

    // R1: masters stay blocked for the whole active sequence
    a_r1_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> master_block_o);

    // R3: refresh is off whenever self-refresh is requested
    a_r3_rf_off_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
        sr_req_o |-> refresh_off_o);

    // R4: the clock switch is only requested with self-refresh held
    a_r4_clk_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
        clk_req_o |-> sr_req_o);

    // R5: PHY init command is one of the two legal words
    a_r5_init_word: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_sel_o == 3'd2 && s_q.state == ST_PHY_POLL) |->
        (wr_data_o == PHY_INIT_BYP || wr_data_o == PHY_INIT_PLL));

    // R7: gate extend is cleared in the write that precedes training
    a_r7_gate_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_sel_o == 3'd3 && s_q.state == ST_TRAIN) |->
        (wr_data_o[7:6] == 2'b00));

    // R10: done is a single cycle and coincides with busy falling
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R11: an error leaves the sequencer not busy
    a_r11_err_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !busy_o);

endmodule

// File: tb/dfs_freq_seq_bench.sv
module dfs_freq_seq_bench;

    localparam int PRE = 20;
    localparam int EXI = 200;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_i;
    logic [11:0] target_mhz_i;
    logic [2:0]  dram_type_i;
    logic [11:0] trefi_nom_i;
    logic [31:0] zq_cur_i, rfsh_cur_i, gate_cur_i;
    logic [15:0] tmo_limit_i;
    logic [2:0]  opmode_i;
    logic        clk_ack_i, phy_done_i;
    logic        busy_o, done_o, err_o, master_block_o, refresh_off_o;
    logic        sr_req_o, clk_req_o, wr_valid_o;
    logic [11:0] clk_tgt_o;
    logic [2:0]  wr_sel_o;
    logic [31:0] wr_data_o;

    always #5 clk = ~clk;

    dfs_freq_seq #(
        .FREQ_W(12), .TMO_W(16), .CLK_MHZ(1), .PRE_US(PRE), .EXIT_US(EXI)
    ) u_dfs_freq_seq (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .target_mhz_i(target_mhz_i),
        .dram_type_i(dram_type_i), .trefi_nom_i(trefi_nom_i), .zq_cur_i(zq_cur_i),
        .rfsh_cur_i(rfsh_cur_i), .gate_cur_i(gate_cur_i), .tmo_limit_i(tmo_limit_i),
        .opmode_i(opmode_i), .clk_ack_i(clk_ack_i), .phy_done_i(phy_done_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .master_block_o(master_block_o),
        .refresh_off_o(refresh_off_o), .sr_req_o(sr_req_o), .clk_req_o(clk_req_o),
        .clk_tgt_o(clk_tgt_o), .wr_valid_o(wr_valid_o), .wr_sel_o(wr_sel_o),
        .wr_data_o(wr_data_o)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // external models
    bit stall_sr = 1'b0;
    int opc = 0, ackc = 0, phyc = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            opmode_i = 3'd1; clk_ack_i = 1'b0; phy_done_i = 1'b1;
            opc = 0; ackc = 0; phyc = 0;
        end else begin
            if (sr_req_o && !stall_sr && opmode_i != 3'd3) begin
                opc++;
                if (opc >= 3) begin opmode_i = 3'd3; opc = 0; end
            end else if (!sr_req_o && opmode_i == 3'd3) begin
                opc++;
                if (opc >= 3) begin opmode_i = 3'd1; opc = 0; end
            end else begin
                opc = 0;
            end
            if (clk_req_o) begin
                ackc++;
                clk_ack_i = (ackc >= 2);
            end else begin
                ackc = 0; clk_ack_i = 1'b0;
            end
            if (wr_valid_o && wr_sel_o == 3'd2) begin
                phy_done_i = 1'b0; phyc = 4;
            end else if (phyc > 0) begin
                phyc--;
                if (phyc == 0) phy_done_i = 1'b1;
            end
        end
    end

    // event log
    int cyc = 0;
    int n_wr;
    logic [2:0]  lsel [16];
    logic [31:0] ldat [16];
    int          lcyc [16];
    int m_rise, m_fall, sr_rise, sr_fall, rf_rise, rf_fall, e_rise, d_cyc, d_cnt;
    bit busy_at_done;
    bit pm = 0, ps = 0, pr = 0, pe = 0;

    task automatic clear_log();
        n_wr = 0; m_rise = -1; m_fall = -1; sr_rise = -1; sr_fall = -1;
        rf_rise = -1; rf_fall = -1; e_rise = -1; d_cyc = -1; d_cnt = 0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (wr_valid_o && n_wr < 16) begin
                lsel[n_wr] = wr_sel_o; ldat[n_wr] = wr_data_o; lcyc[n_wr] = cyc; n_wr++;
            end
            if (master_block_o && !pm) m_rise = cyc;
            if (!master_block_o && pm) m_fall = cyc;
            if (sr_req_o && !ps) sr_rise = cyc;
            if (!sr_req_o && ps) sr_fall = cyc;
            if (refresh_off_o && !pr) rf_rise = cyc;
            if (!refresh_off_o && pr) rf_fall = cyc;
            if (err_o && !pe) e_rise = cyc;
            if (done_o) begin d_cyc = cyc; d_cnt++; busy_at_done = busy_o; end
            pm = master_block_o; ps = sr_req_o; pr = refresh_off_o; pe = err_o;
        end
    end

    task automatic wait_end(input bit want_err);
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (want_err ? (e_rise >= 0) : (d_cnt > 0)) break;
        end
    endtask

    task automatic run(input int f, input logic [2:0] t, input int idx,
                       input bit intrude, input bit timing);
        logic [11:0] nom, fld;
        logic [31:0] zq, rf, gt;
        logic [2:0]  esel [8];
        logic [31:0] edat [8];
        int ne;
        bool_byp: begin end
        nom = 12'(780 + 17 * idx);
        zq  = 32'hA5A5_FFFF ^ (idx << 3);
        rf  = 32'h1234_5678 + idx;
        gt  = 32'h0000_00C5 ^ idx;
        clear_log();
        target_mhz_i = 12'(f); dram_type_i = t; trefi_nom_i = nom;
        zq_cur_i = zq; rfsh_cur_i = rf; gate_cur_i = gt; tmo_limit_i = 16'd200;
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        // R1: accepted request raises busy and block in the next cycle
        chk(busy_o && master_block_o, "R1 accept", {30'd0, busy_o, master_block_o}, 32'd3);
        if (intrude) begin
            repeat (30) @(negedge clk);
            target_mhz_i = 12'(f ^ 12'h3FF); dram_type_i = 3'd2;
            zq_cur_i = 32'h0; rfsh_cur_i = 32'h0; gate_cur_i = 32'h0;
            req_i = 1'b1;
            @(negedge clk);
            req_i = 1'b0;
            // R1: ignored request leaves the captured target on the clock port
            chk(clk_tgt_o == 12'(f), "R1 ignore", {20'd0, clk_tgt_o}, f);
        end
        wait_end(1'b0);
        fld = (f < 300) ? (nom >> 2) : (f < 672) ? (nom >> 1) : nom;
        ne = 0;
        esel[ne] = 3'd0; edat[ne] = zq & ~32'h3800; ne++;
        esel[ne] = 3'd1; edat[ne] = (rf & ~32'h0FFF_0000) | ({20'd0, fld} << 16); ne++;
        esel[ne] = 3'd2; edat[ne] = (f <= 800) ? 32'h4002_0061 : 32'h4000_0071; ne++;
        esel[ne] = 3'd3; edat[ne] = gt & ~32'hC0; ne++;
        esel[ne] = 3'd2;
        edat[ne] = (t == 3'd3) ? ((f <= 800) ? 32'h4002_0C01 : 32'h4000_0C01)
                               : ((f <= 800) ? 32'h4002_0401 : 32'h4000_0401);
        ne++;
        if (t == 3'd3) begin
            esel[ne] = 3'd4; edat[ne] = (f < 400) ? 32'h0 : 32'h2211; ne++;
        end
        if (t == 3'd6 || t == 3'd7) begin
            esel[ne] = 3'd3; edat[ne] = (gt & ~32'hC0) | 32'h40; ne++;
        end
        esel[ne] = 3'd0; edat[ne] = zq; ne++;
        // R10: exactly one done pulse with busy low
        chk(d_cnt == 1 && !busy_at_done, "R10 done", d_cnt, 1);
        // R8 R9: number of writes depends on type
        chk(n_wr == ne, "R8_R9 write count", n_wr, ne);
        if (n_wr == ne) begin
            chk(lsel[0] == esel[0] && ldat[0] == edat[0], "R2 zq clear", ldat[0], edat[0]);
            chk(lsel[1] == esel[1] && ldat[1] == edat[1], "R3 refresh word", ldat[1], edat[1]);
            chk(lsel[2] == esel[2] && ldat[2] == edat[2], "R5 init word", ldat[2], edat[2]);
            chk(lsel[3] == esel[3] && ldat[3] == edat[3], "R7 gate clear", ldat[3], edat[3]);
            chk(lsel[4] == esel[4] && ldat[4] == edat[4], "R7 train word", ldat[4], edat[4]);
            for (int k = 5; k < ne - 1; k++)
                chk(lsel[k] == esel[k] && ldat[k] == edat[k], "R8_R9 post-train write",
                    ldat[k], edat[k]);
            chk(lsel[ne-1] == 3'd0 && ldat[ne-1] == zq, "R10 zq restore", ldat[ne-1], zq);
            if (timing) begin
                chk(lcyc[0] - m_rise == PRE, "R2 pre delay", lcyc[0] - m_rise, PRE);
                chk(rf_rise == lcyc[1], "R3 refresh off rise", rf_rise, lcyc[1]);
                chk(rf_fall == lcyc[ne-1], "R3 refresh off fall", rf_fall, lcyc[ne-1]);
                chk(sr_rise == lcyc[1] + 1, "R4 sr request", sr_rise, lcyc[1] + 1);
                chk(lcyc[3] - sr_fall == EXI + 1, "R6 exit delay", lcyc[3] - sr_fall, EXI + 1);
                chk(lcyc[4] == lcyc[3] + 1, "R7 train follows", lcyc[4], lcyc[3] + 1);
                chk(m_fall == d_cyc && d_cyc == lcyc[ne-1] + 1, "R10 unblock", m_fall, lcyc[ne-1] + 1);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int idx;
        int freqs [10];
        logic [2:0] types [4];
        freqs = '{100, 299, 300, 399, 400, 671, 672, 800, 801, 933};
        types = '{3'd3, 3'd6, 3'd7, 3'd2};
        rst_n = 1'b0; req_i = 1'b0; target_mhz_i = '0; dram_type_i = '0;
        trefi_nom_i = '0; zq_cur_i = '0; rfsh_cur_i = '0; gate_cur_i = '0;
        tmo_limit_i = 16'd200;
        clear_log();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R10 R11: reset state is idle and quiet
        chk(!busy_o && !master_block_o && !err_o && !sr_req_o && !wr_valid_o && !refresh_off_o,
            "R1 reset state",
            {26'd0, busy_o, master_block_o, err_o, sr_req_o, wr_valid_o, refresh_off_o}, 0);
        idx = 0;
        foreach (freqs[i]) begin
            foreach (types[j]) begin
                run(freqs[i], types[j], idx, 1'b0, 1'b1);
                repeat (3) @(negedge clk);
                idx++;
            end
        end
        // R1: request during busy is ignored
        run(250, 3'd3, 7, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        // R11: self-refresh never reached
        stall_sr = 1'b1;
        clear_log();
        target_mhz_i = 12'd500; dram_type_i = 3'd3; tmo_limit_i = 16'd10;
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        wait_end(1'b1);
        chk(e_rise - sr_rise == 11, "R11 timeout delay", e_rise - sr_rise, 11);
        chk(!busy_o && master_block_o && sr_req_o && d_cnt == 0, "R11 error levels",
            {29'd0, busy_o, master_block_o, sr_req_o}, 32'd3);
        stall_sr = 1'b0;
        repeat (5) @(negedge clk);
        // R11: restart from error completes
        run(700, 3'd7, 3, 1'b0, 1'b0);
        chk(!err_o, "R11 error cleared", err_o, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule